// File: doc/BRIEF.md
# Serial Port Sample Rate Generator

This block makes the bit clock and the frame-sync pulse for a synchronous serial port. All logic runs on one system clock. A source tick is taken from one of three places: the system clock itself, or a rising edge on the receive or transmit clock pin. A pin source can be inverted before the edge is found. Three counters are chained. A divider turns source ticks into the generated clock `clkg_o`. A frame counter counts generated-clock periods between frame starts. The pulse-width comparison holds `fsg_o` high for the first part of every frame.

An optional resync mode watches an external frame-sync input. On a rising edge of that input it restarts the divider and the frame counter together, so that both outputs line up with the incoming pulse. A small routing stage picks which clock appears on the receive clock, transmit clock and receive shift clock outputs. The choice follows the clock-mode, loopback and clock-stop settings. All settings are plain input ports, meant to be driven from a register bank.

Top module: `sample_rate_gen`

## Requirements
- R1: Source select `src_sel` = 00 or 01 gives one source tick on every system clock cycle. The value 10 gives a tick on each rising edge of `rx_clk_pin`, and 11 gives a tick on each rising edge of `tx_clk_pin`.
- R2: When `rx_pin_pol` (for select 10) or `tx_pin_pol` (for select 11) is 1, the pin is inverted before edge detection. A falling pin edge then produces the tick.
- R3: A divide value N gives a `clkg_o` period of N+1 source ticks. The high phase lasts ceil((N+1)/2) ticks and the low phase lasts the rest. N = 0 is treated as N = 1.
- R4: A frame-period value P places P+1 `clkg_o` periods between successive rising edges of `fsg_o`. Every `fsg_o` rising edge coincides with a `clkg_o` rising edge.
- R5: A frame-width value W holds `fsg_o` high for W+1 `clkg_o` periods. If W >= P, `fsg_o` stays high all the time.
- R6: While `gen_en` is 0, `clkg_o` and `fsg_o` are 0 and all counters are cleared. The first source tick after `gen_en` rises starts a `clkg_o` high phase and a frame.
- R7: With `sync_en` = 1, a rising edge on `fs_in` passes through a two-stage synchronizer. It then restarts the divider and the frame counter. `clkg_o` and `fsg_o` both rise on the third system clock edge after `fs_in` rises. The next frame starts P+1 periods later.
- R8: With `sync_en` = 0, `fs_in` has no effect on either output.
- R9: With `rx_clk_mode` = 1, `rx_clk_o` is `clkg_o` when `loopback_en` is 0, and the internal transmit clock when `loopback_en` is 1. With `rx_clk_mode` = 0 it is `rx_clk_pin`.
- R10: `tx_clk_o` is `clkg_o` when `tx_clk_mode` = 1, and `tx_clk_pin` otherwise.
- R11: When `clk_stop_mode[1]` is 1 (codes 10b, 11b), `rx_shift_clk_o` follows `tx_clk_o`. For codes 00b and 01b it follows `rx_clk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_en | input | 1 | Generator run enable |
| src_sel | input | 2 | Source tick select |
| rx_pin_pol | input | 1 | Invert receive clock pin as source |
| tx_pin_pol | input | 1 | Invert transmit clock pin as source |
| div_val | input | DIV_W | Clock divide value N |
| per_val | input | PER_W | Frame period value P |
| wid_val | input | WID_W | Frame pulse width value W |
| sync_en | input | 1 | Enable resync to fs_in |
| fs_in | input | 1 | External frame-sync input |
| rx_clk_mode | input | 1 | Receive clock driven internally |
| tx_clk_mode | input | 1 | Transmit clock driven by clkg |
| loopback_en | input | 1 | Digital loopback routing |
| clk_stop_mode | input | 2 | Clock-stop code |
| rx_clk_pin | input | 1 | Receive clock pin input |
| tx_clk_pin | input | 1 | Transmit clock pin input |
| clkg_o | output | 1 | Generated clock |
| fsg_o | output | 1 | Generated frame-sync pulse |
| rx_clk_o | output | 1 | Receive clock output |
| tx_clk_o | output | 1 | Transmit clock output |
| rx_shift_clk_o | output | 1 | Clock used by receive shifter |

## Verification
The assertions assume that the pin sources and `fs_in` change only between system clock edges. They also assume that `div_val`, `per_val` and `wid_val` stay fixed while `gen_en` is 1. The stimulus meets both conditions: it drives every input on the falling edge, and it changes the settings only after dropping `gen_en`. A pin toggles no faster than every three system cycles, which keeps `clkg_o` at or below half the source rate.

// File: rtl/srg_pkg.sv
package srg_pkg;
   typedef enum logic [1:0] {
      SRC_SYS_A  = 2'b00,
      SRC_SYS_B  = 2'b01,
      SRC_RX_PIN = 2'b10,
      SRC_TX_PIN = 2'b11
   } srg_src_e;

   function automatic logic stop_active(input logic [1:0] code);
      return code[1];
   endfunction
endpackage

// File: rtl/srg_src_sel.sv
module srg_src_sel
   import srg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] src_sel,
   input  logic       rx_pin,
   input  logic       tx_pin,
   input  logic       rx_pol,
   input  logic       tx_pol,
   output logic       tick_o
);
   srg_src_e sel_e;
   logic     pin_lvl;
   logic     pin_prev_q;
   logic     use_pin;

   assign sel_e = srg_src_e'(src_sel);

   always_comb begin
      use_pin = 1'b1;
      pin_lvl = 1'b0;
      unique case (sel_e)
         SRC_RX_PIN: pin_lvl = rx_pin ^ rx_pol;
         SRC_TX_PIN: pin_lvl = tx_pin ^ tx_pol;
         default:    use_pin = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev_q <= 1'b0;
      else        pin_prev_q <= pin_lvl;
   end

   assign tick_o = use_pin ? (pin_lvl & ~pin_prev_q) : 1'b1;
endmodule

// File: rtl/srg_clk_div.sv
module srg_clk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic             restart_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             clkg_o,
   output logic             rise_o
);
   localparam int CW = DIV_W + 1;

   logic [DIV_W-1:0] n_eff;
   logic [DIV_W-1:0] cnt_q;
   logic [CW-1:0]    cnt_nx;
   logic [CW-1:0]    hi_len;
   logic             armed_q;
   logic             clkg_q;
   logic             wrap;

   assign n_eff  = (div_i == '0) ? DIV_W'(1) : div_i;
   assign hi_len = ({1'b0, n_eff} + CW'(2)) >> 1;
   assign cnt_nx = {1'b0, cnt_q} + CW'(1);
   assign wrap   = !armed_q || (cnt_q >= n_eff);
   assign rise_o = run_i && (restart_i || (tick_i && wrap));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         clkg_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q   <= '0;
         clkg_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (restart_i || (tick_i && wrap)) begin
         cnt_q   <= '0;
         clkg_q  <= 1'b1;
         armed_q <= 1'b1;
      end else if (tick_i) begin
         cnt_q   <= cnt_nx[DIV_W-1:0];
         clkg_q  <= (cnt_nx < hi_len);
      end
   end

   assign clkg_o = clkg_q;

   assert_clkg_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clkg_q) |-> $past(tick_i || restart_i));
   assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !clkg_q);
   assert_restart_aligns_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_i && run_i) |=> clkg_q);
endmodule

// File: rtl/srg_frame_cnt.sv
module srg_frame_cnt #(
   parameter int PER_W = 12,
   parameter int WID_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             rise_i,
   input  logic             restart_i,
   input  logic [PER_W-1:0] per_i,
   input  logic [WID_W-1:0] wid_i,
   output logic             fsg_o
);
   localparam int CW = PER_W + 1;

   logic [PER_W-1:0] fcnt_q;
   logic [PER_W-1:0] wid_ext;
   logic [PER_W-1:0] w_eff;
   logic [CW-1:0]    fcnt_nx;
   logic             armed_q;
   logic             fsg_q;

   assign wid_ext = PER_W'(wid_i);
   assign w_eff   = (wid_ext >= per_i) ? per_i : wid_ext;
   assign fcnt_nx = {1'b0, fcnt_q} + CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt_q  <= '0;
         fsg_q   <= 1'b0;
         armed_q <= 1'b0;
      end else if (!run_i) begin
         fcnt_q  <= '0;
         fsg_q   <= 1'b0;
         armed_q <= 1'b0;
      end else if (rise_i) begin
         armed_q <= 1'b1;
         if (restart_i || !armed_q || (fcnt_q >= per_i)) begin
            fcnt_q <= '0;
            fsg_q  <= 1'b1;
         end else begin
            fcnt_q <= fcnt_nx[PER_W-1:0];
            fsg_q  <= (fcnt_nx <= {1'b0, w_eff});
         end
      end
   end

   assign fsg_o = fsg_q;

   assert_fsg_rise_on_clkg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsg_q) |-> $past(rise_i));
   assert_fsg_fall_on_clkg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fsg_q) |-> ($past(rise_i) || !$past(run_i)));
endmodule

// File: rtl/srg_clk_route.sv
module srg_clk_route
   import srg_pkg::*;
(
   input  logic       clkg_i,
   input  logic       rx_clk_mode,
   input  logic       tx_clk_mode,
   input  logic       loopback_en,
   input  logic [1:0] clk_stop_mode,
   input  logic       rx_clk_pin,
   input  logic       tx_clk_pin,
   output logic       rx_clk_o,
   output logic       tx_clk_o,
   output logic       rx_shift_clk_o
);
   logic tx_int;
   logic rx_int;

   always_comb begin
      tx_int = tx_clk_mode ? clkg_i : tx_clk_pin;
      if (rx_clk_mode) rx_int = loopback_en ? tx_int : clkg_i;
      else             rx_int = rx_clk_pin;
   end

   assign tx_clk_o       = tx_int;
   assign rx_clk_o       = rx_int;
   assign rx_shift_clk_o = stop_active(clk_stop_mode) ? tx_int : rx_int;
endmodule

// File: rtl/sample_rate_gen.sv
module sample_rate_gen #(
   parameter int DIV_W       = 8,
   parameter int PER_W       = 12,
   parameter int WID_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gen_en,
   input  logic [1:0]       src_sel,
   input  logic             rx_pin_pol,
   input  logic             tx_pin_pol,
   input  logic [DIV_W-1:0] div_val,
   input  logic [PER_W-1:0] per_val,
   input  logic [WID_W-1:0] wid_val,
   input  logic             sync_en,
   input  logic             fs_in,
   input  logic             rx_clk_mode,
   input  logic             tx_clk_mode,
   input  logic             loopback_en,
   input  logic [1:0]       clk_stop_mode,
   input  logic             rx_clk_pin,
   input  logic             tx_clk_pin,
   output logic             clkg_o,
   output logic             fsg_o,
   output logic             rx_clk_o,
   output logic             tx_clk_o,
   output logic             rx_shift_clk_o
);
   if (DIV_W < 2) begin : g_bad_div
      $error("DIV_W must be at least 2");
   end
   if (WID_W > PER_W) begin : g_bad_wid
      $error("WID_W must not exceed PER_W");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 0..4");
   end

   logic tick;
   logic fs_s;
   logic fs_prev_q;
   logic restart;
   logic clkg_rise;
   logic clkg;

   if (SYNC_STAGES == 0) begin : g_fs_direct
      assign fs_s = fs_in;
   end else begin : g_fs_sync
      logic [SYNC_STAGES-1:0] st_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= '0;
         else        st_q <= {st_q[SYNC_STAGES-2:0], fs_in};
      end
      assign fs_s = st_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fs_prev_q <= 1'b0;
      else        fs_prev_q <= fs_s;
   end

   assign restart = sync_en && gen_en && fs_s && !fs_prev_q;

   srg_src_sel u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_sel (src_sel),
      .rx_pin  (rx_clk_pin),
      .tx_pin  (tx_clk_pin),
      .rx_pol  (rx_pin_pol),
      .tx_pol  (tx_pin_pol),
      .tick_o  (tick)
   );

   srg_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (gen_en),
      .tick_i    (tick),
      .restart_i (restart),
      .div_i     (div_val),
      .clkg_o    (clkg),
      .rise_o    (clkg_rise)
   );

   srg_frame_cnt #(.PER_W(PER_W), .WID_W(WID_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (gen_en),
      .rise_i    (clkg_rise),
      .restart_i (restart),
      .per_i     (per_val),
      .wid_i     (wid_val),
      .fsg_o     (fsg_o)
   );

   srg_clk_route u_route (
      .clkg_i         (clkg),
      .rx_clk_mode    (rx_clk_mode),
      .tx_clk_mode    (tx_clk_mode),
      .loopback_en    (loopback_en),
      .clk_stop_mode  (clk_stop_mode),
      .rx_clk_pin     (rx_clk_pin),
      .tx_clk_pin     (tx_clk_pin),
      .rx_clk_o       (rx_clk_o),
      .tx_clk_o       (tx_clk_o),
      .rx_shift_clk_o (rx_shift_clk_o)
   );

   assign clkg_o = clkg;

   assert_fs_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_en && gen_en && !clkg_rise) |=> $stable(fsg_o));
endmodule

// File: tb/sample_rate_gen_tb.sv
module sample_rate_gen_tb_top;
   localparam int DW = 8;
   localparam int PW = 12;
   localparam int WW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gen_en = 1'b0;
   logic [1:0] src_sel = 2'b00;
   logic rx_pin_pol = 1'b0, tx_pin_pol = 1'b0;
   logic [DW-1:0] div_val = '0;
   logic [PW-1:0] per_val = '0;
   logic [WW-1:0] wid_val = '0;
   logic sync_en = 1'b0, fs_in = 1'b0;
   logic rx_clk_mode = 1'b0, tx_clk_mode = 1'b0, loopback_en = 1'b0;
   logic [1:0] clk_stop_mode = 2'b00;
   logic rx_clk_pin = 1'b0, tx_clk_pin = 1'b0;
   logic clkg_o, fsg_o, rx_clk_o, tx_clk_o, rx_shift_clk_o;

   int n_chk = 0;
   int n_bad = 0;
   logic pin_run = 1'b0;
   int pin_cnt = 0;

   always #2 clk = ~clk;

   sample_rate_gen #(.DIV_W(DW), .PER_W(PW), .WID_W(WW)) dut_i (
      .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .src_sel(src_sel),
      .rx_pin_pol(rx_pin_pol), .tx_pin_pol(tx_pin_pol),
      .div_val(div_val), .per_val(per_val), .wid_val(wid_val),
      .sync_en(sync_en), .fs_in(fs_in),
      .rx_clk_mode(rx_clk_mode), .tx_clk_mode(tx_clk_mode),
      .loopback_en(loopback_en), .clk_stop_mode(clk_stop_mode),
      .rx_clk_pin(rx_clk_pin), .tx_clk_pin(tx_clk_pin),
      .clkg_o(clkg_o), .fsg_o(fsg_o), .rx_clk_o(rx_clk_o),
      .tx_clk_o(tx_clk_o), .rx_shift_clk_o(rx_shift_clk_o)
   );

   // pin toggles every 3 cycles (period 6) when enabled
   always @(negedge clk) begin
      if (pin_run) begin
         pin_cnt <= (pin_cnt == 2) ? 0 : pin_cnt + 1;
         if (pin_cnt == 2) rx_clk_pin <= ~rx_clk_pin;
      end
   end

   // N, P, W, clkg high, clkg period, fsg high, fsg period (system cycles)
   localparam int NV = 4;
   localparam int V_N [NV]  = '{1, 2, 7, 0};
   localparam int V_P [NV]  = '{3, 4, 2, 1};
   localparam int V_W [NV]  = '{0, 1, 0, 0};
   localparam int E_CH[NV]  = '{1, 2, 4, 1};
   localparam int E_CP[NV]  = '{2, 3, 8, 2};
   localparam int E_FH[NV]  = '{2, 6, 8, 2};
   localparam int E_FP[NV]  = '{8, 15, 24, 4};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic measure(input bit sel_fsg, output int hi, output int per);
      int g;
      g = 0;
      while (((sel_fsg ? fsg_o : clkg_o) !== 1'b0) && g < 2000) begin @(negedge clk); g++; end
      while (((sel_fsg ? fsg_o : clkg_o) !== 1'b1) && g < 2000) begin @(negedge clk); g++; end
      hi = 0; per = 0;
      while (((sel_fsg ? fsg_o : clkg_o) === 1'b1) && g < 2000) begin @(negedge clk); hi++; g++; end
      per = hi;
      while (((sel_fsg ? fsg_o : clkg_o) === 1'b0) && g < 2000) begin @(negedge clk); per++; g++; end
   endtask

   task automatic restart_gen();
      @(negedge clk); gen_en = 1'b0;
      @(negedge clk); gen_en = 1'b1;
   endtask

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int hi, per, bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 reset/idle state
      check(clkg_o === 1'b0 && fsg_o === 1'b0, "R6 reset idle", {clkg_o, fsg_o}, 0);
      div_val = 3; per_val = 2;
      bad = 0;
      repeat (10) begin @(negedge clk); if (clkg_o !== 1'b0 || fsg_o !== 1'b0) bad++; end
      check(bad == 0, "R6 disabled holds low", bad, 0);

      // R3 R4 R5 vector loop, internal source (R1)
      for (int i = 0; i < NV; i++) begin
         @(negedge clk); gen_en = 1'b0;
         div_val = DW'(V_N[i]); per_val = PW'(V_P[i]); wid_val = WW'(V_W[i]);
         @(negedge clk); gen_en = 1'b1;
         @(negedge clk);
         check(clkg_o === 1'b1 && fsg_o === 1'b1, "R6 start on first tick", {clkg_o, fsg_o}, 3);
         measure(1'b0, hi, per);
         check(hi == E_CH[i], "R3 clkg high", hi, E_CH[i]);
         check(per == E_CP[i], "R3 R1 clkg period", per, E_CP[i]);
         measure(1'b1, hi, per);
         check(hi == E_FH[i], "R5 fsg width", hi, E_FH[i]);
         check(per == E_FP[i], "R4 fsg period", per, E_FP[i]);
      end

      // R5 clipping: W >= P keeps fsg high
      @(negedge clk); gen_en = 1'b0;
      div_val = 1; per_val = 2; wid_val = 5;
      @(negedge clk); gen_en = 1'b1;
      @(negedge clk);
      bad = 0;
      repeat (40) begin if (fsg_o !== 1'b1) bad++; @(negedge clk); end
      check(bad == 0, "R5 clipped width stays high", bad, 0);

      // R1 pin source: rx pin toggles every 3 cycles, N=1 -> high 6, period 12
      @(negedge clk); gen_en = 1'b0;
      src_sel = 2'b10; div_val = 1; per_val = 3; wid_val = 0;
      pin_run = 1'b1;
      @(negedge clk); gen_en = 1'b1;
      measure(1'b0, hi, per);
      check(hi == 6, "R1 rx pin source high", hi, 6);
      check(per == 12, "R1 rx pin source period", per, 12);
      @(negedge clk); pin_run = 1'b0; gen_en = 1'b0;

      // R2 polarity: tx pin inverted, falling edge ticks
      src_sel = 2'b11; tx_pin_pol = 1'b1; tx_clk_pin = 1'b1;
      @(negedge clk); @(negedge clk); gen_en = 1'b1;
      repeat (4) @(negedge clk);
      check(clkg_o === 1'b0, "R2 no tick while inverted level low", clkg_o, 0);
      tx_clk_pin = 1'b0;
      @(negedge clk);
      check(clkg_o === 1'b1, "R2 falling pin edge ticks", clkg_o, 1);
      gen_en = 1'b0; tx_pin_pol = 1'b0;

      // R8 fs_in ignored when sync disabled
      src_sel = 2'b00; div_val = 7; per_val = 9; wid_val = 0; sync_en = 1'b0;
      @(negedge clk); gen_en = 1'b1;
      repeat (30) @(negedge clk);
      fs_in = 1'b1;
      bad = 0;
      repeat (6) begin @(negedge clk); if (fsg_o !== 1'b0) bad++; end
      check(bad == 0, "R8 fs_in ignored", bad, 0);
      fs_in = 1'b0;

      // R7 resync
      restart_gen();
      sync_en = 1'b1;
      repeat (30) @(negedge clk);
      fs_in = 1'b1;
      @(negedge clk); @(negedge clk);
      check(fsg_o === 1'b0, "R7 no early frame", fsg_o, 0);
      @(negedge clk);
      check(clkg_o === 1'b1 && fsg_o === 1'b1, "R7 aligned on third edge", {clkg_o, fsg_o}, 3);
      fs_in = 1'b0;
      hi = 0;
      while (fsg_o === 1'b1 && hi < 500) begin hi++; @(negedge clk); end
      per = hi;
      while (fsg_o === 1'b0 && per < 500) begin per++; @(negedge clk); end
      check(hi == 8, "R7 width after resync", hi, 8);
      check(per == 80, "R7 period reloaded", per, 80);
      sync_en = 1'b0;

      // R9 R10 R11 routing with clkg toggling (N=1)
      restart_gen();
      div_val = 1;
      rx_clk_mode = 1'b1; tx_clk_mode = 1'b1; loopback_en = 1'b0;
      bad = 0;
      repeat (8) begin @(negedge clk); if (rx_clk_o !== clkg_o || tx_clk_o !== clkg_o) bad++; end
      check(bad == 0, "R9 R10 clocks from clkg", bad, 0);
      tx_clk_mode = 1'b0; loopback_en = 1'b1;
      bad = 0;
      for (int k = 0; k < 8; k++) begin
         tx_clk_pin = k[0];
         @(negedge clk);
         if (rx_clk_o !== tx_clk_pin || tx_clk_o !== tx_clk_pin) bad++;
      end
      check(bad == 0, "R9 loopback follows tx clock", bad, 0);
      rx_clk_mode = 1'b0; loopback_en = 1'b0; rx_clk_pin = 1'b0;
      clk_stop_mode = 2'b10;
      bad = 0;
      for (int k = 0; k < 8; k++) begin
         tx_clk_pin = k[1];
         @(negedge clk);
         if (rx_shift_clk_o !== tx_clk_pin || rx_clk_o !== 1'b0) bad++;
      end
      check(bad == 0, "R11 clock stop uses tx clock", bad, 0);
      clk_stop_mode = 2'b01; rx_clk_mode = 1'b1;
      bad = 0;
      repeat (8) begin @(negedge clk); if (rx_shift_clk_o !== clkg_o) bad++; end
      check(bad == 0, "R11 no clock stop uses rx clock", bad, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule